// File: doc/BRIEF.md
# USB endpoint packet buffer

This block holds the packets of one USB endpoint and works on whole packets rather than a byte stream. A single input picks its role. As a transmit endpoint, software writes bytes and then raises a ready flag, and a USB transmitter later asks for the packet and receives it byte by byte. As a receive endpoint, a USB receiver delivers a packet, and software reads its bytes and then frees the slot.

A size input sets the per-slot capacity in its low field. Its top bit selects double buffering, which provides two slots used in ping-pong order. In that mode one packet can be filled while the other is drained. A host/peripheral input sets which USB direction the endpoint serves. In host mode a receive endpoint accepts a packet only after software has armed it with a request flag.

Completed transactions raise a one-cycle interrupt pulse when the interrupt is enabled. A transmit request that finds no packet is flagged as an underrun. A receive packet that arrives with no free slot, or before a host-mode request, is dropped and flagged as rejected.

Top module: `ep_pkt_buffer`

## Requirements
- R1: After reset the slot count is 0, and the ready flag, the request flag, the interrupt and the transmit valid are all 0.
- R2: `usb_dir_in` is 1 (IN token served) for a receive endpoint in host mode and for a transmit endpoint in peripheral mode. It is 0 in the other two combinations.
- R3: On a transmit endpoint, bytes written by software and committed with `cpu_txrdy_set` raise the slot count and `tx_ready_flag`. Once `usb_tx_start` is sampled, the bytes appear in write order on `usb_tx_data`, one per cycle with `usb_tx_valid`, starting the next cycle. A one-cycle `usb_tx_done` follows the last byte, and the slot count then drops by one.
- R4: With single buffering and one packet pending, further byte writes and ready requests are ignored. The count stays 1 and the pending packet is sent unchanged.
- R5: With double buffering, two committed packets can wait at once. A third commit is ignored, and the two packets are sent in commit order.
- R6: `usb_tx_start` with no packet pending produces a one-cycle `usb_tx_underrun` in the following cycle and no valid byte.
- R7: On a receive endpoint in peripheral mode, a packet ended by `usb_rx_end` is stored whenever a slot is free. Software then sees the count rise and `pkt_len` equal to the byte count, reads the bytes in order on `cpu_rd_data` (advancing with `cpu_rd_en`), and frees the slot with `cpu_rx_unload`.
- R8: In host mode a receive endpoint accepts a packet only while `reqpkt_flag` is set. The flag is set by `cpu_reqpkt_set` and clears when a packet is stored. A packet that arrives unarmed is rejected.
- R9: When every slot is full (one single-buffered, two double-buffered), a further packet is rejected with a one-cycle `usb_rx_reject` in the cycle after its end. The stored packets are unchanged. With double buffering, a new packet can be received into one slot while the other is being read.
- R10: The capacity is the low field of `cfg_size`, limited to MAX_PKT. Bytes past the capacity are dropped, and the stored length equals the capacity.
- R11: `ep_irq` pulses for one cycle, in the cycle after `usb_tx_done` or after a stored receive packet ends, only when `int_en` is 1.
- R12: A receive endpoint ignores `usb_tx_start` (no underrun, no data). A transmit endpoint ignores receive traffic (count unchanged, no reject).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_size | input | LEN_W+1 | Top bit: double buffering; low field: slot capacity in bytes |
| cfg_host | input | 1 | 1 = host mode, 0 = peripheral mode |
| ep_is_tx | input | 1 | 1 = transmit endpoint, 0 = receive endpoint |
| int_en | input | 1 | Interrupt enable |
| cpu_wr_en | input | 1 | Software byte write (transmit role) |
| cpu_wr_data | input | DATA_W | Byte written by software |
| cpu_txrdy_set | input | 1 | Commit the filled slot as ready to send |
| cpu_rd_en | input | 1 | Advance to the next received byte |
| cpu_rd_data | output | DATA_W | Current received byte of the head slot |
| cpu_rx_unload | input | 1 | Free the head receive slot |
| cpu_reqpkt_set | input | 1 | Arm a host-mode receive |
| usb_tx_start | input | 1 | Transmitter requests the next packet |
| usb_tx_valid | output | 1 | Transmit byte valid |
| usb_tx_data | output | DATA_W | Transmit byte |
| usb_tx_done | output | 1 | Packet fully handed over |
| usb_tx_underrun | output | 1 | Request found no packet |
| usb_rx_valid | input | 1 | Received byte valid |
| usb_rx_data | input | DATA_W | Received byte |
| usb_rx_end | input | 1 | End of received packet |
| usb_rx_accept | output | 1 | A new packet would be accepted now |
| usb_rx_reject | output | 1 | Last packet was dropped |
| usb_dir_in | output | 1 | Endpoint serves IN tokens |
| ep_pkt_count | output | 2 | Occupied slots |
| pkt_len | output | LEN_W | Length of the head slot |
| tx_ready_flag | output | 1 | A transmit packet is pending |
| reqpkt_flag | output | 1 | Host-mode receive armed |
| ep_irq | output | 1 | Transaction-complete interrupt pulse |

## Verification
The bench builds the buffer with MAX_PKT = 8 and 8-bit data, which makes the capacity field 4 bits wide and the size input 5 bits wide. With these values a single field setting above the slot size exercises the clamp, and a field of 3 exercises truncation. Both slots can be filled and overfilled within a few dozen cycles, so full-slot rejection, ping-pong order and the overlap of reception with reading are all reached by short directed packets.

// File: rtl/ep_pkt_buffer_pkg.sv
package ep_pkt_buffer_pkg;
  typedef enum logic {
    TXE_IDLE = 1'b0,
    TXE_SEND = 1'b1
  } txe_state_t;

  function automatic logic [1:0] slot_limit(input logic dbl);
    return dbl ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/ep_rst_sync.sv
module ep_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/ep_pkt_ram.sv
module ep_pkt_ram #(
  parameter int DATA_W = 8,
  parameter int AW     = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ep_slot_ctrl.sv
module ep_slot_ctrl #(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbl,
  input  logic             fill_en,
  input  logic             fill_commit,
  input  logic             drain_step,
  input  logic             drain_release,
  output logic [1:0]       count,
  output logic             wr_slot,
  output logic             rd_slot,
  output logic [LEN_W-1:0] fill_idx,
  output logic [LEN_W-1:0] drain_idx,
  output logic [LEN_W-1:0] head_len
);
  logic [1:0]            count_q, count_d;
  logic                  wr_q, wr_d, rd_q, rd_d;
  logic [LEN_W-1:0]      fill_q, fill_d, drain_q, drain_d;
  logic [1:0][LEN_W-1:0] len_q, len_d;

  always_comb begin
    wr_d    = wr_q;
    rd_d    = rd_q;
    fill_d  = fill_q;
    drain_d = drain_q;
    len_d   = len_q;
    if (fill_en) fill_d = fill_q + 1'b1;
    if (fill_commit) begin
      len_d[wr_q] = fill_q;
      fill_d      = '0;
      wr_d        = dbl ? ~wr_q : 1'b0;
    end
    if (drain_step) drain_d = drain_q + 1'b1;
    if (drain_release) begin
      drain_d = '0;
      rd_d    = dbl ? ~rd_q : 1'b0;
    end
    count_d = count_q + {1'b0, fill_commit} - {1'b0, drain_release};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= 2'd0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      fill_q  <= '0;
      drain_q <= '0;
      len_q   <= '0;
    end else begin
      count_q <= count_d;
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      fill_q  <= fill_d;
      drain_q <= drain_d;
      len_q   <= len_d;
    end
  end

  assign count     = count_q;
  assign wr_slot   = wr_q;
  assign rd_slot   = rd_q;
  assign fill_idx  = fill_q;
  assign drain_idx = drain_q;
  assign head_len  = len_q[rd_q];
endmodule

// File: rtl/ep_pkt_buffer.sv
module ep_pkt_buffer
  import ep_pkt_buffer_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_PKT = 64,
  localparam int IDX_W  = $clog2(MAX_PKT),
  localparam int LEN_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W:0]    cfg_size,
  input  logic              cfg_host,
  input  logic              ep_is_tx,
  input  logic              int_en,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wr_data,
  input  logic              cpu_txrdy_set,
  input  logic              cpu_rd_en,
  output logic [DATA_W-1:0] cpu_rd_data,
  input  logic              cpu_rx_unload,
  input  logic              cpu_reqpkt_set,
  input  logic              usb_tx_start,
  output logic              usb_tx_valid,
  output logic [DATA_W-1:0] usb_tx_data,
  output logic              usb_tx_done,
  output logic              usb_tx_underrun,
  input  logic              usb_rx_valid,
  input  logic [DATA_W-1:0] usb_rx_data,
  input  logic              usb_rx_end,
  output logic              usb_rx_accept,
  output logic              usb_rx_reject,
  output logic              usb_dir_in,
  output logic [1:0]        ep_pkt_count,
  output logic [LEN_W-1:0]  pkt_len,
  output logic              tx_ready_flag,
  output logic              reqpkt_flag,
  output logic              ep_irq
);
  localparam int AW = IDX_W + 1;
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_PKT);

  logic rst_q_n;
  ep_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_q_n));

  // configuration decode
  logic             dbl;
  logic [LEN_W-1:0] cap;
  logic [1:0]       nslots;
  assign dbl    = cfg_size[LEN_W];
  assign cap    = (cfg_size[LEN_W-1:0] > MAX_LEN) ? MAX_LEN : cfg_size[LEN_W-1:0];
  assign nslots = slot_limit(dbl);

  // slot bookkeeping
  logic [1:0]       count;
  logic             wr_slot, rd_slot;
  logic [LEN_W-1:0] fill_idx, drain_idx, head_len;
  logic             fill_en, fill_commit, drain_step, drain_release;
  logic             has_space, has_pkt;

  ep_slot_ctrl #(.LEN_W(LEN_W)) u_slots (
    .clk(clk), .rst_n(rst_q_n), .dbl(dbl),
    .fill_en(fill_en), .fill_commit(fill_commit),
    .drain_step(drain_step), .drain_release(drain_release),
    .count(count), .wr_slot(wr_slot), .rd_slot(rd_slot),
    .fill_idx(fill_idx), .drain_idx(drain_idx), .head_len(head_len)
  );

  assign has_space = (count < nslots);
  assign has_pkt   = (count != 2'd0);

  // packet storage
  logic [DATA_W-1:0] ram_wdata, ram_rdata;
  ep_pkt_ram #(.DATA_W(DATA_W), .AW(AW)) u_ram (
    .clk(clk), .we(fill_en),
    .waddr({wr_slot, fill_idx[IDX_W-1:0]}), .wdata(ram_wdata),
    .raddr({rd_slot, drain_idx[IDX_W-1:0]}), .rdata(ram_rdata)
  );

  // state registers of the control logic
  txe_state_t txe_q, txe_d;
  logic underrun_q, underrun_d;
  logic rx_busy_q, rx_busy_d, rx_drop_q, rx_drop_d;
  logic reject_q, reject_d, reqpkt_q, reqpkt_d, irq_q, irq_d;

  // transmit role
  logic tx_fill, tx_commit, tx_go, tx_release;
  assign tx_fill      = ep_is_tx & cpu_wr_en & has_space & (fill_idx < cap);
  assign tx_commit    = ep_is_tx & cpu_txrdy_set & has_space;
  assign tx_go        = ep_is_tx & usb_tx_start & (txe_q == TXE_IDLE);
  assign usb_tx_valid = (txe_q == TXE_SEND) & (drain_idx < head_len);
  assign usb_tx_done  = (txe_q == TXE_SEND) & (drain_idx == head_len);
  assign usb_tx_data  = ram_rdata;
  assign tx_release   = usb_tx_done;

  // receive role
  logic rx_armed, rx_valid_in, rx_end_in, drop_cur;
  logic rx_fill, rx_commit, rx_step, rx_release;
  assign rx_armed      = ~cfg_host | reqpkt_q;
  assign usb_rx_accept = ~ep_is_tx & has_space & rx_armed;
  assign rx_valid_in   = ~ep_is_tx & usb_rx_valid;
  assign rx_end_in     = ~ep_is_tx & usb_rx_end;
  assign drop_cur      = rx_busy_q ? rx_drop_q : ~usb_rx_accept;
  assign rx_fill       = rx_valid_in & ~drop_cur & (fill_idx < cap);
  assign rx_commit     = rx_end_in & ~drop_cur;
  assign rx_step       = ~ep_is_tx & cpu_rd_en & has_pkt & (drain_idx < head_len);
  assign rx_release    = ~ep_is_tx & cpu_rx_unload & has_pkt;
  assign cpu_rd_data   = ram_rdata;

  // shared slot controls
  assign fill_en       = tx_fill | rx_fill;
  assign fill_commit   = tx_commit | rx_commit;
  assign drain_step    = usb_tx_valid | rx_step;
  assign drain_release = tx_release | rx_release;
  assign ram_wdata     = ep_is_tx ? cpu_wr_data : usb_rx_data;

  always_comb begin
    txe_d = txe_q;
    if (tx_go && has_pkt)  txe_d = TXE_SEND;
    else if (usb_tx_done)  txe_d = TXE_IDLE;
    underrun_d = tx_go & ~has_pkt;

    rx_busy_d = rx_busy_q;
    rx_drop_d = rx_drop_q;
    if (rx_end_in) rx_busy_d = 1'b0;
    else if (rx_valid_in) begin
      rx_busy_d = 1'b1;
      if (!rx_busy_q) rx_drop_d = ~usb_rx_accept;
    end
    reject_d = rx_end_in & drop_cur;

    reqpkt_d = reqpkt_q;
    if (rx_commit) reqpkt_d = 1'b0;
    if (cpu_reqpkt_set && !ep_is_tx && cfg_host) reqpkt_d = 1'b1;

    irq_d = int_en & (usb_tx_done | rx_commit);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      txe_q      <= TXE_IDLE;
      underrun_q <= 1'b0;
      rx_busy_q  <= 1'b0;
      rx_drop_q  <= 1'b0;
      reject_q   <= 1'b0;
      reqpkt_q   <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      txe_q      <= txe_d;
      underrun_q <= underrun_d;
      rx_busy_q  <= rx_busy_d;
      rx_drop_q  <= rx_drop_d;
      reject_q   <= reject_d;
      reqpkt_q   <= reqpkt_d;
      irq_q      <= irq_d;
    end
  end

  assign usb_tx_underrun = underrun_q;
  assign usb_rx_reject   = reject_q;
  assign usb_dir_in      = ep_is_tx ^ cfg_host;
  assign ep_pkt_count    = count;
  assign pkt_len         = head_len;
  assign tx_ready_flag   = ep_is_tx & has_pkt;
  assign reqpkt_flag     = reqpkt_q;
  assign ep_irq          = irq_q;
endmodule

// File: rtl/ep_pkt_buffer_chk.sv
module ep_pkt_buffer_chk #(
  parameter int MAX_PKT = 64,
  localparam int LEN_W  = $clog2(MAX_PKT) + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [LEN_W:0] cfg_size,
  input logic           cfg_host,
  input logic           ep_is_tx,
  input logic           int_en,
  input logic           cpu_txrdy_set,
  input logic           usb_tx_valid,
  input logic           usb_tx_done,
  input logic           usb_tx_underrun,
  input logic           usb_rx_accept,
  input logic [1:0]     ep_pkt_count,
  input logic           reqpkt_flag,
  input logic           ep_irq
);
  // R5, R9: occupancy never exceeds the configured slot number
  p_slot_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ep_pkt_count <= (cfg_size[LEN_W] ? 2'd2 : 2'd1));

  // R6: an underrun only follows a cycle with no pending packet
  p_underrun_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    usb_tx_underrun |-> ($past(ep_pkt_count) == 2'd0));

  // R3: a completed send frees exactly one slot
  p_tx_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_tx_done && !cpu_txrdy_set) |=> (ep_pkt_count == $past(ep_pkt_count) - 2'd1));

  // R8: host-mode acceptance requires an armed request
  p_host_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_rx_accept && cfg_host) |-> reqpkt_flag);

  // R11: an interrupt pulse only when enabled in the cause cycle
  p_irq_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ep_irq |-> $past(int_en));

  // R12: a receive endpoint never drives transmit data
  p_role_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_is_tx |-> (!usb_tx_valid && !usb_tx_done));
endmodule

bind ep_pkt_buffer ep_pkt_buffer_chk #(.MAX_PKT(MAX_PKT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_host(cfg_host),
  .ep_is_tx(ep_is_tx), .int_en(int_en), .cpu_txrdy_set(cpu_txrdy_set),
  .usb_tx_valid(usb_tx_valid), .usb_tx_done(usb_tx_done),
  .usb_tx_underrun(usb_tx_underrun), .usb_rx_accept(usb_rx_accept),
  .ep_pkt_count(ep_pkt_count), .reqpkt_flag(reqpkt_flag), .ep_irq(ep_irq)
);

// File: tb/ep_pkt_buffer_test.sv
module ep_pkt_buffer_test;
  localparam int DW = 8;
  localparam int MP = 8;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [LW:0] cfg_size;
  logic cfg_host, ep_is_tx, int_en;
  logic cpu_wr_en, cpu_txrdy_set, cpu_rd_en, cpu_rx_unload, cpu_reqpkt_set;
  logic [DW-1:0] cpu_wr_data, cpu_rd_data, usb_tx_data, usb_rx_data;
  logic usb_tx_start, usb_tx_valid, usb_tx_done, usb_tx_underrun;
  logic usb_rx_valid, usb_rx_end, usb_rx_accept, usb_rx_reject, usb_dir_in;
  logic [1:0] ep_pkt_count;
  logic [LW-1:0] pkt_len;
  logic tx_ready_flag, reqpkt_flag, ep_irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] cap_buf [16];
  int  tx_n;
  logic tx_irq;

  always #2.5 clk = ~clk;

  ep_pkt_buffer #(.DATA_W(DW), .MAX_PKT(MP)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_host(cfg_host),
    .ep_is_tx(ep_is_tx), .int_en(int_en), .cpu_wr_en(cpu_wr_en),
    .cpu_wr_data(cpu_wr_data), .cpu_txrdy_set(cpu_txrdy_set),
    .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data),
    .cpu_rx_unload(cpu_rx_unload), .cpu_reqpkt_set(cpu_reqpkt_set),
    .usb_tx_start(usb_tx_start), .usb_tx_valid(usb_tx_valid),
    .usb_tx_data(usb_tx_data), .usb_tx_done(usb_tx_done),
    .usb_tx_underrun(usb_tx_underrun), .usb_rx_valid(usb_rx_valid),
    .usb_rx_data(usb_rx_data), .usb_rx_end(usb_rx_end),
    .usb_rx_accept(usb_rx_accept), .usb_rx_reject(usb_rx_reject),
    .usb_dir_in(usb_dir_in), .ep_pkt_count(ep_pkt_count), .pkt_len(pkt_len),
    .tx_ready_flag(tx_ready_flag), .reqpkt_flag(reqpkt_flag), .ep_irq(ep_irq)
  );

  // {cfg_host, ep_is_tx, expected usb_dir_in}
  localparam logic [2:0] DIR_VEC [4] = '{3'b000, 3'b011, 3'b101, 3'b110};

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cpu_wr_en = 0; cpu_txrdy_set = 0; cpu_rd_en = 0; cpu_rx_unload = 0;
    cpu_reqpkt_set = 0; usb_tx_start = 0; usb_rx_valid = 0; usb_rx_end = 0;
    cpu_wr_data = '0; usb_rx_data = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic cpu_load(input int len, input logic [7:0] base);
    for (int i = 0; i < len; i++) begin
      cpu_wr_en = 1'b1; cpu_wr_data = base + 8'(i); tick();
    end
    cpu_wr_en = 1'b0;
    cpu_txrdy_set = 1'b1; tick(); cpu_txrdy_set = 1'b0;
  endtask

  task automatic tx_send();
    usb_tx_start = 1'b1; tick(); usb_tx_start = 1'b0;
    tx_n = 0; tx_irq = 1'b0;
    for (int c = 0; c < 20; c++) begin
      if (usb_tx_valid) begin cap_buf[tx_n] = usb_tx_data; tx_n++; end
      if (usb_tx_done) begin tick(); tx_irq = ep_irq; break; end
      tick();
    end
  endtask

  task automatic tx_expect(input int len, input logic [7:0] base, input string tag);
    chk(tx_n == len, tag, tx_n, len);
    for (int i = 0; i < len && i < 16; i++)
      chk(cap_buf[i] == base + 8'(i), tag, int'(cap_buf[i]), int'(base + 8'(i)));
  endtask

  task automatic rx_pkt(input int len, input logic [7:0] base);
    for (int i = 0; i < len; i++) begin
      usb_rx_valid = 1'b1; usb_rx_data = base + 8'(i); tick();
    end
    usb_rx_valid = 1'b0;
    usb_rx_end = 1'b1; tick(); usb_rx_end = 1'b0;
  endtask

  task automatic rx_read(input int len, input logic [7:0] base, input string tag);
    chk(int'(pkt_len) == len, tag, int'(pkt_len), len);
    for (int i = 0; i < len; i++) begin
      chk(cpu_rd_data == base + 8'(i), tag, int'(cpu_rd_data), int'(base + 8'(i)));
      cpu_rd_en = 1'b1; tick(); cpu_rd_en = 1'b0;
    end
    cpu_rx_unload = 1'b1; tick(); cpu_rx_unload = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cfg_size = {1'b0, 4'd8}; cfg_host = 1'b0; ep_is_tx = 1'b1; int_en = 1'b1;
    do_reset();

    // R1: reset state
    chk(ep_pkt_count == 0, "R1 count", int'(ep_pkt_count), 0);
    chk(!tx_ready_flag && !reqpkt_flag && !ep_irq && !usb_tx_valid, "R1 flags",
        int'({tx_ready_flag, reqpkt_flag, ep_irq, usb_tx_valid}), 0);

    // R2: direction table
    for (int v = 0; v < 4; v++) begin
      cfg_host = DIR_VEC[v][2]; ep_is_tx = DIR_VEC[v][1]; #1;
      chk(usb_dir_in == DIR_VEC[v][0], "R2 dir", int'(usb_dir_in), int'(DIR_VEC[v][0]));
    end
    cfg_host = 1'b0; ep_is_tx = 1'b1; tick();

    // R3: single packet send
    cpu_load(3, 8'hA1);
    chk(ep_pkt_count == 1 && tx_ready_flag, "R3 ready", int'(ep_pkt_count), 1);
    // R4: further load ignored while full
    cpu_load(2, 8'hE0);
    chk(ep_pkt_count == 1, "R4 count", int'(ep_pkt_count), 1);
    tx_send();
    tx_expect(3, 8'hA1, "R3/R4 data");
    chk(tx_irq == 1'b1, "R11 tx irq", int'(tx_irq), 1);
    chk(ep_pkt_count == 0 && !tx_ready_flag, "R3 release", int'(ep_pkt_count), 0);

    // R6: underrun
    usb_tx_start = 1'b1; tick(); usb_tx_start = 1'b0;
    chk(usb_tx_underrun == 1'b1 && !usb_tx_valid, "R6 underrun", int'(usb_tx_underrun), 1);
    tick();
    chk(usb_tx_underrun == 1'b0, "R6 pulse", int'(usb_tx_underrun), 0);

    // R5: double buffering
    cfg_size = {1'b1, 4'd8};
    cpu_load(2, 8'hB0);
    cpu_load(4, 8'hC0);
    cpu_load(1, 8'hD0);
    chk(ep_pkt_count == 2, "R5 count", int'(ep_pkt_count), 2);
    tx_send();
    tx_expect(2, 8'hB0, "R5 first");
    chk(ep_pkt_count == 1, "R5 after first", int'(ep_pkt_count), 1);
    tx_send();
    tx_expect(4, 8'hC0, "R5 second");
    chk(ep_pkt_count == 0, "R5 empty", int'(ep_pkt_count), 0);

    // R10: capacity truncation and clamp
    cfg_size = {1'b0, 4'd3};
    cpu_load(5, 8'h10);
    tx_send();
    tx_expect(3, 8'h10, "R10 cap3");
    cfg_size = {1'b0, 4'd15};
    cpu_load(10, 8'h20);
    tx_send();
    tx_expect(8, 8'h20, "R10 clamp");

    // R11: interrupt disabled
    int_en = 1'b0; cfg_size = {1'b0, 4'd8};
    cpu_load(1, 8'h55);
    tx_send();
    chk(tx_irq == 1'b0, "R11 masked", int'(tx_irq), 0);
    int_en = 1'b1;

    // R12: transmit endpoint ignores receive traffic
    rx_pkt(2, 8'h77);
    chk(ep_pkt_count == 0 && !usb_rx_reject, "R12 tx ignores rx", int'(ep_pkt_count), 0);

    // R7: receive, peripheral, single
    do_reset();
    ep_is_tx = 1'b0; cfg_host = 1'b0; cfg_size = {1'b0, 4'd8}; tick();
    chk(usb_rx_accept == 1'b1, "R7 accept", int'(usb_rx_accept), 1);
    rx_pkt(4, 8'h30);
    chk(ep_irq == 1'b1 && !usb_rx_reject, "R11 rx irq", int'(ep_irq), 1);
    chk(ep_pkt_count == 1, "R7 count", int'(ep_pkt_count), 1);
    // R9: full, reject
    rx_pkt(2, 8'h90);
    chk(usb_rx_reject == 1'b1, "R9 reject", int'(usb_rx_reject), 1);
    chk(ep_pkt_count == 1, "R9 count", int'(ep_pkt_count), 1);
    rx_read(4, 8'h30, "R7/R9 data");
    chk(ep_pkt_count == 0, "R7 unload", int'(ep_pkt_count), 0);
    // R12: receive endpoint ignores transmit request
    usb_tx_start = 1'b1; tick(); usb_tx_start = 1'b0;
    chk(!usb_tx_underrun && !usb_tx_valid, "R12 rx ignores tx", int'(usb_tx_underrun), 0);

    // R9: double receive with overlap
    cfg_size = {1'b1, 4'd8}; tick();
    rx_pkt(2, 8'h40);
    rx_pkt(3, 8'h50);
    chk(ep_pkt_count == 2, "R9 two held", int'(ep_pkt_count), 2);
    rx_pkt(1, 8'h60);
    chk(usb_rx_reject == 1'b1, "R9 third reject", int'(usb_rx_reject), 1);
    rx_read(2, 8'h40, "R9 first");
    rx_pkt(1, 8'h70);
    chk(!usb_rx_reject && ep_pkt_count == 2, "R9 overlap", int'(ep_pkt_count), 2);
    rx_read(3, 8'h50, "R9 second");
    rx_read(1, 8'h70, "R9 third");

    // R8: host mode request
    cfg_host = 1'b1; cfg_size = {1'b0, 4'd8}; tick();
    chk(usb_rx_accept == 1'b0, "R8 unarmed", int'(usb_rx_accept), 0);
    rx_pkt(2, 8'h81);
    chk(usb_rx_reject == 1'b1 && ep_pkt_count == 0, "R8 reject", int'(usb_rx_reject), 1);
    cpu_reqpkt_set = 1'b1; tick(); cpu_reqpkt_set = 1'b0;
    chk(reqpkt_flag == 1'b1 && usb_rx_accept, "R8 armed", int'(reqpkt_flag), 1);
    rx_pkt(2, 8'h82);
    chk(ep_pkt_count == 1 && !reqpkt_flag, "R8 stored", int'(ep_pkt_count), 1);
    rx_read(2, 8'h82, "R8 data");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule